// File: doc/BRIEF.md
# Transmit Sample Queue with Control and Status Word

This block is the transmit-side sample buffer of a serial audio port together with its control and status word. A bus-side register interface pushes 32-bit sample words into a 32-entry first-in first-out store, and it reads and writes one control/status word and one configuration word. On the serial side, the shift logic pops one word at a time and reports frame boundaries and frame-sync errors back to the block.

The block keeps three sticky event flags and two live level flags, each with its own interrupt-enable bit, and drives one interrupt line and one DMA request line. Software can flush the store in a single cycle, hold the whole block in soft reset, and start or stop the transfer. A stop request takes effect only at the next frame boundary reported by the serial side.

Top module: `aud_txq_top`

## Requirements
- R1: After the synchronous reset `rst`, the control word (address 0) reads 32'h0018_0000: only the empty flag (bit 19) and the request flag (bit 20) are set. `irq`, `dma_req`, `xfer_active` and `ser_data` are 0.
- R2: Each bus write to address 1 appends `bus_wdata` to the store when it holds fewer than 32 words, and a write to a full store is dropped. Each `ser_pop` accepted while running presents the oldest word on `ser_data` in the next cycle, in order.
- R3: A `ser_pop` accepted while running with the store empty is an underrun. It drives `ser_data` to 0 and sets the sticky underrun flag, bit 18.
- R4: Each accepted pop sets the sticky word-start flag (bit 16), and `ser_fs_err` while running sets the sticky frame-error flag (bit 17). Writing 1 to bit 16, 17 or 18 of the control word clears that flag and writing 0 leaves it unchanged. A new event in the same cycle as a clear keeps the flag set.
- R5: Bit 19 reads 1 exactly when the store is empty. Bit 20 reads 1 exactly when the fill level is at or below the watermark in bits 4:0 of the configuration word (address 2). Writes to bits 19 and 20 have no effect.
- R6: Writing 1 to control bit 2 empties the store in one cycle. A pop in that same cycle is ignored, and bit 2 always reads 0.
- R7: While control bit 3 reads 1, every other piece of state is held at its reset value and pushes and pops are ignored. Writing 0 to bit 3 releases the block.
- R8: Control bit 0 starts the transfer and `xfer_active` mirrors its read value. Pops are ignored while the block is stopped. After software writes 0, bit 0 keeps reading 1 and pops are still served until a cycle with `ser_frame_end` high.
- R9: `irq` is registered. It is 1 one cycle after any of the five flags (bits 20:16) is set together with its enable in bits 12:8 at the same position.
- R10: `dma_req` is registered. It equals control bit 1 ANDed with the request flag of the previous cycle.
- R11: `bus_rdata` is registered and shows the word at `bus_addr` as it stood before the clock edge. Address 0 gives the control word, address 2 gives the watermark, and address 1 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 2 | Word address: 0 control, 1 sample data, 2 configuration |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| ser_pop | input | 1 | Shift logic requests the next sample word |
| ser_frame_end | input | 1 | Frame boundary strobe from the shift logic |
| ser_fs_err | input | 1 | Frame-sync error strobe from the shift logic |
| ser_data | output | 32 | Sample word delivered by the last accepted pop |
| xfer_active | output | 1 | Transfer running (read value of control bit 0) |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The store is filled to the watermark, to exactly full and past full, then drained until it underruns. These patterns separate ordering faults, a dropped overflow write and the zero underrun word. Clears of sticky flags are tried alone, mixed with writes of 0 to other flags, and in the same cycle as a new event, which shows whether the clear or the set has priority. A stop request is issued several cycles before a frame boundary to show that pops are still served until the boundary. A long random phase mixes pushes, pops, flushes, soft resets, boundaries and watermark changes. In every cycle it compares all outputs with a queue-based model, which catches timing slips of the registered interrupt, DMA and read paths.

// File: rtl/aud_txq_pkg.sv
package aud_txq_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] A_CFG  = 2'd2;

  // control word bit positions
  localparam int B_EN    = 0;
  localparam int B_DMA   = 1;
  localparam int B_FLUSH = 2;
  localparam int B_SRST  = 3;
  localparam int B_IE    = 8;
  localparam int B_FLAG  = 16;

  // flag vector order: 0 word-start, 1 frame error, 2 underrun, 3 empty, 4 request
  localparam int NFLAG   = 5;
  localparam int NSTICKY = 3;

  typedef struct packed {
    logic                 en;
    logic                 dma;
    logic                 flush;
    logic                 srst;
    logic [NFLAG-1:0]     ie;
    logic [NSTICKY-1:0]   clr;
  } ctrl_wr_t;
endpackage

// File: rtl/aud_txq_store.sv
module aud_txq_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_all,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          has_data;

  assign has_data = (count != '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + AW'(1);
      if (pop && has_data) rd_ptr <= rd_ptr + AW'(1);
      count <= count + CW'(push) - CW'(pop && has_data);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_all) pop_data <= '0;
    else if (pop) pop_data <= has_data ? mem[rd_ptr] : '0;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst_all)
    count <= CW'(DEPTH)); // R2
  AST_UNDERRUN_ZERO: assert property (@(posedge clk) disable iff (rst_all)
    (pop && !has_data && !clr) |=> (pop_data == '0)); // R3
endmodule

// File: rtl/aud_txq_csr.sv
module aud_txq_csr
  import aud_txq_pkg::*;
#(
  parameter int DW  = 32,
  parameter int CW  = 6,
  parameter int WMW = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  ctrl_wr_t          ctrl_wd,
  input  logic              cfg_we,
  input  logic [WMW-1:0]    cfg_wm,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              ser_frame_end,
  input  logic              ser_fs_err,
  input  logic              pop_ok,
  input  logic [CW-1:0]     fifo_count,
  output logic              flush_o,
  output logic              srst_o,
  output logic              en_run_o,
  output logic              irq_o,
  output logic              dma_req_o
);
  logic                soft_q, en_sw_q, en_run_q, dma_en_q;
  logic [NFLAG-1:0]    ie_q;
  logic [NSTICKY-1:0]  sticky_q, sticky_n;
  logic [WMW-1:0]      wm_q;
  logic [NFLAG-1:0]    flags;
  logic                req_live, empty_live, en_sw_n;
  logic [DW-1:0]       ctrl_view, view;

  assign srst_o     = soft_q | (ctrl_we & ctrl_wd.srst);
  assign flush_o    = ctrl_we & ctrl_wd.flush & ~srst_o;
  assign en_run_o   = en_run_q;
  assign empty_live = (fifo_count == '0);
  assign req_live   = (fifo_count <= CW'(wm_q));
  assign flags      = {req_live, empty_live, sticky_q};
  assign en_sw_n    = ctrl_we ? ctrl_wd.en : en_sw_q;

  always_comb begin
    sticky_n = sticky_q;
    if (ctrl_we) sticky_n = sticky_n & ~ctrl_wd.clr;
    if (pop_ok) sticky_n[0] = 1'b1;
    if (ser_fs_err && en_run_q) sticky_n[1] = 1'b1;
    if (pop_ok && empty_live) sticky_n[2] = 1'b1;
  end

  always_comb begin
    ctrl_view = '0;
    ctrl_view[B_EN]   = en_run_q;
    ctrl_view[B_DMA]  = dma_en_q;
    ctrl_view[B_SRST] = soft_q;
    ctrl_view[B_IE +: NFLAG]   = ie_q;
    ctrl_view[B_FLAG +: NFLAG] = flags;
    case (rd_addr)
      A_CTRL:  view = ctrl_view;
      A_CFG:   view = DW'(wm_q);
      default: view = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      soft_q  <= 1'b0;
    end else begin
      rd_data <= view;
      if (srst_o) soft_q <= ctrl_we ? ctrl_wd.srst : 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || srst_o) begin
      en_sw_q   <= 1'b0;
      en_run_q  <= 1'b0;
      dma_en_q  <= 1'b0;
      ie_q      <= '0;
      sticky_q  <= '0;
      wm_q      <= '0;
      irq_o     <= 1'b0;
      dma_req_o <= 1'b0;
    end else begin
      irq_o     <= |(flags & ie_q);
      dma_req_o <= dma_en_q & req_live;
      en_sw_q   <= en_sw_n;
      en_run_q  <= en_sw_n | (en_run_q & ~ser_frame_end);
      sticky_q  <= sticky_n;
      if (ctrl_we) begin
        dma_en_q <= ctrl_wd.dma;
        ie_q     <= ctrl_wd.ie;
      end
      if (cfg_we) wm_q <= cfg_wm;
    end
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    flush_o |=> (fifo_count == '0)); // R6
  AST_STOP_WAITS_FRAME: assert property (@(posedge clk) disable iff (rst)
    (en_run_q && !ser_frame_end && !srst_o) |=> en_run_q); // R8
  AST_SOFT_QUIET: assert property (@(posedge clk) disable iff (rst)
    soft_q |-> (!irq_o && !dma_req_o && fifo_count == '0)); // R7
  AST_DMA_GATED: assert property (@(posedge clk) disable iff (rst)
    !dma_en_q |=> !dma_req_o); // R10
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (ie_q == '0) |=> !irq_o); // R9
endmodule

// File: rtl/aud_txq_top.sv
module aud_txq_top
  import aud_txq_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter int WMW   = 5,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              ser_pop,
  input  logic              ser_frame_end,
  input  logic              ser_fs_err,
  output logic [DW-1:0]     ser_data,
  output logic              xfer_active,
  output logic              irq,
  output logic              dma_req
);
  logic          ctrl_we, cfg_we, flush, srst_now, en_run, pop_ok, push;
  logic [CW-1:0] count;
  ctrl_wr_t      cwd;

  assign ctrl_we = bus_we && (bus_addr == A_CTRL);
  assign cfg_we  = bus_we && (bus_addr == A_CFG);
  assign cwd.en    = bus_wdata[B_EN];
  assign cwd.dma   = bus_wdata[B_DMA];
  assign cwd.flush = bus_wdata[B_FLUSH];
  assign cwd.srst  = bus_wdata[B_SRST];
  assign cwd.ie    = bus_wdata[B_IE +: NFLAG];
  assign cwd.clr   = bus_wdata[B_FLAG +: NSTICKY];

  assign push   = bus_we && (bus_addr == A_DATA) && !srst_now && (count != CW'(DEPTH));
  assign pop_ok = ser_pop && en_run && !flush && !srst_now;
  assign xfer_active = en_run;

  aud_txq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_all   (rst | srst_now),
    .clr       (rst | srst_now | flush),
    .push      (push),
    .push_data (bus_wdata),
    .pop       (pop_ok),
    .pop_data  (ser_data),
    .count     (count)
  );

  aud_txq_csr #(.DW(DW), .CW(CW), .WMW(WMW)) u_csr (
    .clk           (clk),
    .rst           (rst),
    .ctrl_we       (ctrl_we),
    .ctrl_wd       (cwd),
    .cfg_we        (cfg_we),
    .cfg_wm        (bus_wdata[WMW-1:0]),
    .rd_addr       (bus_addr),
    .rd_data       (bus_rdata),
    .ser_frame_end (ser_frame_end),
    .ser_fs_err    (ser_fs_err),
    .pop_ok        (pop_ok),
    .fifo_count    (count),
    .flush_o       (flush),
    .srst_o        (srst_now),
    .en_run_o      (en_run),
    .irq_o         (irq),
    .dma_req_o     (dma_req)
  );

  initial begin
    AST_DEPTH_POW2: assert ((DEPTH & (DEPTH - 1)) == 0); // R2
  end
endmodule

// File: tb/aud_txq_top_tb.sv
`timescale 1ns/1ps
module aud_txq_top_tb;
  logic        clk = 1'b0, rst = 1'b1;
  logic        bus_we = 1'b0, ser_pop = 1'b0, ser_frame_end = 1'b0, ser_fs_err = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, ser_data;
  logic        xfer_active, irq, dma_req;

  int total = 0, bad = 0;
  bit done = 0, started = 0;

  always #2.5 clk = ~clk;

  aud_txq_top u_dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ser_pop(ser_pop), .ser_frame_end(ser_frame_end),
    .ser_fs_err(ser_fs_err), .ser_data(ser_data), .xfer_active(xfer_active),
    .irq(irq), .dma_req(dma_req)
  );

  // ---------------- reference model ----------------
  logic [31:0] mq[$];
  logic        m_srst, m_en_sw, m_en_run, m_dma, m_irq, m_dreq;
  logic [4:0]  m_ie, m_wm, fl;
  logic [2:0]  m_st, nst;
  logic [31:0] m_ser, m_rdata, nrd;
  logic        cw, fls, ensn, popk;
  int          sz;

  function automatic logic [31:0] view(input logic [1:0] a);
    logic [31:0] v;
    v = '0;
    if (a == 2'd0) v = {11'b0, fl, 3'b0, m_ie, 4'b0, m_srst, 1'b0, m_dma, m_en_run};
    else if (a == 2'd2) v = {27'b0, m_wm};
    return v;
  endfunction

  always @(posedge clk) begin
    sz  = mq.size();
    fl  = {(sz <= int'(m_wm)), (sz == 0), m_st};
    nrd = view(bus_addr);
    if (rst) begin
      mq.delete();
      {m_srst, m_en_sw, m_en_run, m_dma, m_irq, m_dreq} = '0;
      m_ie = '0; m_wm = '0; m_st = '0; m_ser = '0; m_rdata = '0;
      started = 1;
    end else begin
      m_rdata = nrd;
      cw = bus_we && bus_addr == 2'd0;
      if (m_srst || (cw && bus_wdata[3])) begin
        m_srst = cw ? bus_wdata[3] : 1'b1;
        mq.delete();
        {m_en_sw, m_en_run, m_dma, m_irq, m_dreq} = '0;
        m_ie = '0; m_wm = '0; m_st = '0; m_ser = '0;
      end else begin
        m_irq  = |(fl & m_ie);
        m_dreq = m_dma && (sz <= int'(m_wm));
        fls  = cw && bus_wdata[2];
        ensn = cw ? bus_wdata[0] : m_en_sw;
        popk = ser_pop && m_en_run && !fls;
        nst  = m_st;
        if (cw) nst = nst & ~bus_wdata[18:16];
        if (popk) nst[0] = 1'b1;
        if (ser_fs_err && m_en_run) nst[1] = 1'b1;
        if (popk) begin
          if (sz == 0) begin nst[2] = 1'b1; m_ser = '0; end
          else m_ser = mq.pop_front();
        end
        if (bus_we && bus_addr == 2'd1 && sz < 32) mq.push_back(bus_wdata);
        if (fls) mq.delete();
        m_en_run = ensn | (m_en_run & ~ser_frame_end);
        m_en_sw  = ensn;
        if (cw) begin m_dma = bus_wdata[1]; m_ie = bus_wdata[12:8]; end
        if (bus_we && bus_addr == 2'd2) m_wm = bus_wdata[4:0];
        m_st = nst;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst && !done) begin
      check("R2 ser_data vs model", ser_data, m_ser);
      check("R8 xfer_active vs model", {31'b0, xfer_active}, {31'b0, m_en_run});
      check("R9 irq vs model", {31'b0, irq}, {31'b0, m_irq});
      check("R10 dma_req vs model", {31'b0, dma_req}, {31'b0, m_dreq});
      check("R11 bus_rdata vs model", bus_rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    bus_we = 1'b0; bus_addr = a;
    tick();
    d = bus_rdata;
  endtask

  task automatic pop1();
    ser_pop = 1'b1; tick(); ser_pop = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  logic [31:0] v;
  initial begin
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    rd(2'd0, v);
    check("R1 reset control word", v, 32'h0018_0000);
    check("R1 reset irq", {31'b0, irq}, 32'd0);
    check("R1 reset ser_data", ser_data, 32'd0);

    // watermark 4, five words queued
    wr(2'd2, 32'd4);
    for (int i = 0; i < 5; i++) wr(2'd1, 32'hA000_0000 + i);
    rd(2'd0, v);
    check("R5 level flags above watermark", {30'b0, v[20:19]}, 32'd0);
    wr(2'd1, 32'hFFFF_FFFF);
    pop1();
    check("R8 pop ignored while stopped", ser_data, 32'd0);

    // start, all enables, DMA on
    wr(2'd0, 32'h0000_1F03);
    pop1();
    check("R2 first word", ser_data, 32'hA000_0000);
    pop1();
    check("R2 second word", ser_data, 32'hA000_0001);
    rd(2'd0, v);
    check("R4 word-start flag set", {31'b0, v[16]}, 32'd1);
    for (int i = 0; i < 4; i++) pop1();
    check("R2 sixth word", ser_data, 32'hFFFF_FFFF);
    ser_data_dirty();
    pop1();
    check("R3 underrun data zero", ser_data, 32'd0);
    rd(2'd0, v);
    check("R3 underrun flag", {31'b0, v[18]}, 32'd1);
    check("R5 empty flag", {31'b0, v[19]}, 32'd1);

    // clear word-start only, write 0 to underrun, try writing live bits
    wr(2'd0, 32'h0019_1F03);
    rd(2'd0, v);
    check("R4 word-start cleared", {31'b0, v[16]}, 32'd0);
    check("R4 underrun kept", {31'b0, v[18]}, 32'd1);
    check("R9 irq from underrun", {31'b0, irq}, 32'd1);
    // clear in same cycle as new event
    bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h0001_1F03; ser_pop = 1'b1;
    tick();
    bus_we = 1'b0; ser_pop = 1'b0;
    rd(2'd0, v);
    check("R4 set wins over clear", {31'b0, v[16]}, 32'd1);
    ser_fs_err = 1'b1; tick(); ser_fs_err = 1'b0;
    rd(2'd0, v);
    check("R4 frame error flag", {31'b0, v[17]}, 32'd1);

    // stop request waits for frame end
    wr(2'd0, 32'h0007_1F02);
    tick(); tick();
    check("R8 still active after stop", {31'b0, xfer_active}, 32'd1);
    ser_frame_end = 1'b1; tick(); ser_frame_end = 1'b0;
    check("R8 stopped at frame end", {31'b0, xfer_active}, 32'd0);

    // fill past full, then drain
    for (int i = 0; i < 33; i++) wr(2'd1, 32'h100 + i);
    wr(2'd0, 32'h0000_0001);
    for (int i = 0; i < 32; i++) pop1();
    check("R2 last of full store", ser_data, 32'h11F);
    pop1();
    check("R2 overflow word dropped", ser_data, 32'd0);

    // flush
    for (int i = 0; i < 3; i++) wr(2'd1, 32'h55 + i);
    wr(2'd0, 32'h0000_0005);
    rd(2'd0, v);
    check("R6 flush empties", {31'b0, v[19]}, 32'd1);
    check("R6 flush bit reads zero", {31'b0, v[2]}, 32'd0);

    // soft reset
    wr(2'd2, 32'd7);
    wr(2'd0, 32'h0000_1F0B);
    rd(2'd2, v);
    check("R7 watermark held in reset", v, 32'd0);
    check("R7 irq quiet", {31'b0, irq}, 32'd0);
    wr(2'd1, 32'h1234);
    wr(2'd0, 32'h0);
    rd(2'd0, v);
    check("R7 released to reset value", v, 32'h0018_0000);

    // random phase, compared against the model every cycle
    for (int n = 0; n < 4000; n++) begin
      bus_we = ($urandom_range(0, 2) == 0);
      bus_addr = 2'($urandom_range(0, 2));
      bus_wdata = $urandom();
      if (bus_addr == 2'd0) begin
        bus_wdata[3] = ($urandom_range(0, 60) == 0);
        bus_wdata[2] = ($urandom_range(0, 15) == 0);
        bus_wdata[0] = ($urandom_range(0, 5) != 0);
      end
      ser_pop = ($urandom_range(0, 2) == 0);
      ser_frame_end = ($urandom_range(0, 12) == 0);
      ser_fs_err = ($urandom_range(0, 40) == 0);
      tick();
    end
    bus_we = 1'b0; ser_pop = 1'b0; ser_frame_end = 1'b0; ser_fs_err = 1'b0;
    tick();
    finish_run();
  end

  task automatic ser_data_dirty();
    // placeholder-free helper: one idle cycle before the underrun pop
    tick();
  endtask
endmodule